// File: doc/BRIEF.md
# Serial Configuration EEPROM Loader

This block copies the contents of a three-wire serial configuration EEPROM into an on-chip shadow memory as soon as reset is released. It drives chip select, a divided serial clock and a serial data line toward the EEPROM, and it takes the EEPROM's serial data output. One read transaction is issued for each of the 64 sixteen-bit words, in ascending order. No other EEPROM command is ever issued.

When the last word has been stored, the block checks whether an EEPROM is actually fitted. A blank or missing part returns a first word of all ones or all zeros. If the part is present, the block assembles a 48-bit station address from image bytes 20 to 25 and raises a valid flag. Other logic can read any stored word through a registered read port and can wait on the done flag before using the address.

Top module: `cfg_rom_loader`

## Requirements
- R1: While reset is asserted, rom_cs, rom_sk and rom_di are low, and load_done, addr_ok and station_addr are zero.
- R2: Each word transaction raises rom_cs with rom_sk low and then gives exactly 25 rising edges of rom_sk before rom_cs falls. The first three rom_di bits are 1, 1, 0.
- R3: The three command bits are followed by a 6-bit word offset, sent most significant bit first. The offsets run 0, 1, ..., 63, one per transaction.
- R4: The 16 bits that follow the offset are sampled from rom_do while rom_sk is high, most significant bit first. The word is stored at its offset. rd_word returns the stored word for rd_idx one clock after rd_idx is applied.
- R5: rom_di changes only while rom_sk is low. It is stable for the whole time rom_sk is high.
- R6: rom_cs falls after the 16th data bit. Between two transactions, rom_cs stays low for at least HALF_DIV clocks. rom_sk is never high while rom_cs is low.
- R7: If word 0 is 16'hFFFF or 16'h0000 (image bytes 0 and 1 both 0xFF or both 0x00), addr_ok stays low and station_addr stays zero.
- R8: If word 0 has any other value, addr_ok goes high. station_addr[47:40] is image byte 20, and the remaining octets follow down to image byte 25 in station_addr[7:0]. Image byte 2k is the low half of word k, and byte 2k+1 is its high half.
- R9: load_done rises once, after the last word has been stored, and then stays high. From then on rom_cs stays low.
- R10: Every high phase of rom_sk lasts exactly HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_cs | output | 1 | EEPROM chip select |
| rom_sk | output | 1 | EEPROM serial clock |
| rom_di | output | 1 | Serial command and offset bits to the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |
| rd_idx | input | 6 | Shadow memory word index |
| rd_word | output | 16 | Shadow memory word, one clock after rd_idx |
| station_addr | output | 48 | Station address; first octet in the top byte |
| addr_ok | output | 1 | Station address valid |
| load_done | output | 1 | Image load complete |

## Verification
On every cycle, the assertions check four things. rom_di holds steady across each clock-high phase. Word offsets advance by one on each store. load_done never falls, and chip select stays quiet after it. addr_ok never appears without load_done, and an invalid address always reads as zero. Only the bench scenarios can show the rest. These are the command and offset bit patterns, the edge count per transaction, the gap and clock-high widths, and the round trip of every stored word. They also cover the decision between present and absent for the all-ones, all-zeros and mixed marker values, and the byte order of the assembled station address.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
   localparam int          OP_W    = 3;
   localparam logic [2:0]  READ_OP = 3'b110;

   typedef enum logic [2:0] {
      PH_GAP,
      PH_SEL,
      PH_LOW,
      PH_HIGH,
      PH_END
   } ser_phase_t;
endpackage

// File: rtl/cfg_rom_tick.sv
module cfg_rom_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("cfg_rom_tick: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/cfg_rom_engine.sv
module cfg_rom_engine
   import cfg_rom_pkg::*;
#(
   parameter int WORDS = 64,
   parameter int DW    = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   output logic                       ser_cs,
   output logic                       ser_sk,
   output logic                       ser_out,
   input  logic                       ser_in,
   output logic                       wr_en,
   output logic [$clog2(WORDS)-1:0]   wr_idx,
   output logic [DW-1:0]              wr_data,
   output logic                       eng_done
);
   localparam int IDXW  = $clog2(WORDS);
   localparam int HDR   = OP_W + IDXW;
   localparam int SLOTS = HDR + DW;
   localparam int SW    = $clog2(SLOTS);
   localparam logic [SW-1:0]   HDR_L  = SW'(HDR);
   localparam logic [SW-1:0]   SLOT_L = SW'(SLOTS - 1);
   localparam logic [IDXW-1:0] LAST_W = IDXW'(WORDS - 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("cfg_rom_engine: DW must be at least 2");
      end
   endgenerate

   ser_phase_t      phase_q;
   logic [SW-1:0]   slot_q;
   logic [IDXW-1:0] word_q;
   logic [DW-1:0]   shreg_q;
   logic [HDR-1:0]  hdr_bits;
   logic [HDR-1:0]  hdr_shift;
   logic            in_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_GAP;
         slot_q  <= '0;
         word_q  <= '0;
         shreg_q <= '0;
      end else if (tick) begin
         unique case (phase_q)
            PH_GAP:  phase_q <= PH_SEL;
            PH_SEL: begin
               phase_q <= PH_LOW;
               slot_q  <= '0;
            end
            PH_LOW:  phase_q <= PH_HIGH;
            PH_HIGH: begin
               if (slot_q >= HDR_L)
                  shreg_q <= {shreg_q[DW-2:0], ser_in};
               if (slot_q == SLOT_L) begin
                  if (word_q == LAST_W) begin
                     phase_q <= PH_END;
                  end else begin
                     word_q  <= word_q + 1'b1;
                     phase_q <= PH_GAP;
                  end
               end else begin
                  slot_q  <= slot_q + 1'b1;
                  phase_q <= PH_LOW;
               end
            end
            PH_END:  phase_q <= PH_END;
            default: phase_q <= PH_GAP;
         endcase
      end
   end

   always_comb begin
      in_bit    = (phase_q == PH_LOW) || (phase_q == PH_HIGH);
      hdr_bits  = {READ_OP, word_q};
      hdr_shift = hdr_bits << slot_q;
      ser_cs    = in_bit || (phase_q == PH_SEL);
      ser_sk    = (phase_q == PH_HIGH);
      ser_out   = (in_bit && (slot_q < HDR_L)) ? hdr_shift[HDR-1] : 1'b0;
   end

   assign wr_en    = tick && (phase_q == PH_HIGH) && (slot_q == SLOT_L);
   assign wr_idx   = word_q;
   assign wr_data  = {shreg_q[DW-2:0], ser_in};
   assign eng_done = (phase_q == PH_END);

   // R5: serial data only moves while the clock is low
   assert_di_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_sk && $past(ser_sk)) |-> $stable(ser_out));

   // R3: offsets advance by one per stored word
   assert_word_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (eng_done || (word_q == IDXW'($past(word_q) + 1'b1))));
endmodule

// File: rtl/cfg_rom_shadow.sv
module cfg_rom_shadow #(
   parameter int WORDS  = 64,
   parameter int DW     = 16,
   parameter bit RD_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(WORDS)-1:0] wr_idx,
   input  logic [DW-1:0]            wr_data,
   input  logic [$clog2(WORDS)-1:0] rd_idx,
   output logic [DW-1:0]            rd_word
);
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_idx] <= wr_data;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk)
            rd_word <= mem[rd_idx];
      end else begin : g_rd_comb
         assign rd_word = mem[rd_idx];
      end
   endgenerate
endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader #(
   parameter int HALF_DIV = 2,
   parameter int WORDS    = 64,
   parameter int DW       = 16,
   parameter int MAC_BYTE = 20,
   parameter bit RD_REG   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic                     rom_cs,
   output logic                     rom_sk,
   output logic                     rom_di,
   input  logic                     rom_do,
   input  logic [$clog2(WORDS)-1:0] rd_idx,
   output logic [DW-1:0]            rd_word,
   output logic [47:0]              station_addr,
   output logic                     addr_ok,
   output logic                     load_done
);
   localparam int IDXW   = $clog2(WORDS);
   localparam int MW0    = MAC_BYTE / 2;
   localparam int NTAP   = 4;

   generate
      if (DW != 16) begin : g_bad_width
         $error("cfg_rom_loader: byte extraction assumes 16-bit words");
      end
      if ((MAC_BYTE % 2) != 0 || (MAC_BYTE + 6) > 2 * WORDS) begin : g_bad_mac
         $error("cfg_rom_loader: MAC_BYTE must be even and inside the image");
      end
      if ((1 << IDXW) != WORDS) begin : g_bad_words
         $error("cfg_rom_loader: WORDS must be a power of two");
      end
   endgenerate

   logic            tick;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [DW-1:0]   wr_data;
   logic            eng_done;

   cfg_rom_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   cfg_rom_engine #(.WORDS(WORDS), .DW(DW)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ser_cs   (rom_cs),
      .ser_sk   (rom_sk),
      .ser_out  (rom_di),
      .ser_in   (rom_do),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .eng_done (eng_done)
   );

   cfg_rom_shadow #(.WORDS(WORDS), .DW(DW), .RD_REG(RD_REG)) u_shadow (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_word (rd_word)
   );

   // tap 0 holds the marker word, taps 1..3 the station address words
   generate
      for (genvar t = 0; t < NTAP; t++) begin : g_tap
         localparam int TI = (t == 0) ? 0 : MW0 + t - 1;
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_idx == IDXW'(TI)))
               q <= wr_data;
         end
      end
   endgenerate

   logic        present;
   logic [47:0] mac_w;

   always_comb begin
      present = !((g_tap[0].q == '1) || (g_tap[0].q == '0));
      mac_w   = {g_tap[1].q[7:0], g_tap[1].q[15:8],
                 g_tap[2].q[7:0], g_tap[2].q[15:8],
                 g_tap[3].q[7:0], g_tap[3].q[15:8]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_done    <= 1'b0;
         addr_ok      <= 1'b0;
         station_addr <= '0;
      end else if (eng_done && !load_done) begin
         load_done    <= 1'b1;
         addr_ok      <= present;
         station_addr <= present ? mac_w : 48'd0;
      end
   end

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !rom_cs);

   assert_valid_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok |-> load_done);

   assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_ok |-> (station_addr == 48'd0));
endmodule

// File: tb/cfg_rom_loader_tb.sv
module cfg_rom_loader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rom_cs, rom_sk, rom_di;
   logic        rom_do = 1'b0;
   logic [5:0]  rd_idx = '0;
   logic [15:0] rd_word;
   logic [47:0] station_addr;
   logic        addr_ok, load_done;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_rom_loader #(.HALF_DIV(HALF)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rom_cs       (rom_cs),
      .rom_sk       (rom_sk),
      .rom_di       (rom_di),
      .rom_do       (rom_do),
      .rd_idx       (rd_idx),
      .rd_word      (rd_word),
      .station_addr (station_addr),
      .addr_ok      (addr_ok),
      .load_done    (load_done)
   );

   // ---------------- EEPROM model and protocol monitors ----------------
   logic [15:0] image [64];
   int          rises, exp_idx, cur;
   logic [8:0]  hdr_sh;
   int          cmd_bad, order_bad, edge_bad, gap_bad, hi_bad, skcs_bad;
   int          low_run, hi_run;

   task automatic clear_monitors();
      rises = 0; exp_idx = 0; cur = 0; hdr_sh = '0;
      cmd_bad = 0; order_bad = 0; edge_bad = 0; gap_bad = 0;
      hi_bad = 0; skcs_bad = 0;
   endtask

   always @(posedge rom_sk) begin
      if (rom_cs) begin
         rises = rises + 1;
         if (rises <= 9) hdr_sh = {hdr_sh[7:0], rom_di};
         if (rises == 9) begin
            cur = int'(hdr_sh[5:0]);
            if (hdr_sh[8:6] != 3'b110) cmd_bad = cmd_bad + 1;
            if (cur != exp_idx) order_bad = order_bad + 1;
            exp_idx = exp_idx + 1;
         end
         if (rises >= 10 && rises <= 25) rom_do <= image[cur][25 - rises];
      end
   end

   always @(negedge rom_cs) begin
      if (rst_n && rises != 25) edge_bad = edge_bad + 1;
      rises = 0;
   end

   always @(posedge rom_cs) begin
      if (low_run < HALF) gap_bad = gap_bad + 1;
   end

   always @(negedge clk) begin
      if (rom_cs) low_run = 0; else low_run = low_run + 1;
      if (rom_sk && !rom_cs) skcs_bad = skcs_bad + 1;
      if (rom_sk) hi_run = hi_run + 1;
      else begin
         if (hi_run != 0 && hi_run != HALF) hi_bad = hi_bad + 1;
         hi_run = 0;
      end
   end

   initial begin low_run = 0; hi_run = 0; clear_monitors(); end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat_word(input int i);
      return (16'h1357 * 16'(i + 1)) ^ 16'hA0C3;
   endfunction

   task automatic fill_image(input logic [15:0] marker);
      for (int i = 0; i < 64; i++) image[i] = pat_word(i);
      image[0] = marker;
   endtask

   task automatic do_load();
      int guard;
      @(negedge clk);
      rst_n = 1'b0;
      clear_monitors();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      guard = 0;
      while (!load_done && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      check(load_done == 1'b1, "R9", "load_done after load", 64'(load_done), 64'd1);
   endtask

   task automatic check_protocol();
      check(cmd_bad == 0, "R2", "read command bits", 64'(cmd_bad), 64'd0);
      check(edge_bad == 0, "R2", "clock edges per word", 64'(edge_bad), 64'd0);
      check(order_bad == 0 && exp_idx == 64, "R3", "offset sequence",
            64'(exp_idx), 64'd64);
      check(gap_bad == 0 && skcs_bad == 0, "R6", "cs gap and sk gating",
            64'(gap_bad + skcs_bad), 64'd0);
      check(hi_bad == 0, "R10", "sk high width", 64'(hi_bad), 64'd0);
   endtask

   task automatic check_shadow();
      int wrong;
      int first_bad;
      logic [15:0] first_val;
      wrong = 0; first_bad = -1; first_val = '0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         rd_idx = 6'(i);
         @(negedge clk);
         if (rd_word !== image[i]) begin
            if (first_bad < 0) begin first_bad = i; first_val = rd_word; end
            wrong++;
         end
      end
      check(wrong == 0, "R4", "shadow words",
            64'(first_val), (first_bad < 0) ? 64'd0 : 64'(image[first_bad]));
   endtask

   task automatic check_quiet();
      int cs_seen;
      int drop;
      cs_seen = 0; drop = 0;
      repeat (300) begin
         @(negedge clk);
         if (rom_cs) cs_seen++;
         if (!load_done) drop++;
      end
      check(cs_seen == 0 && drop == 0, "R9", "quiet and sticky after done",
            64'(cs_seen + drop), 64'd0);
   endtask

   function automatic logic [47:0] exp_mac();
      return {image[10][7:0], image[10][15:8], image[11][7:0],
              image[11][15:8], image[12][7:0], image[12][15:8]};
   endfunction

   // ---------------- scenarios ----------------
   task automatic test_reset_state();
      rst_n = 1'b0;
      #1;
      check({rom_cs, rom_sk, rom_di} == 3'b000, "R1", "serial lines in reset",
            64'({rom_cs, rom_sk, rom_di}), 64'd0);
      check({load_done, addr_ok} == 2'b00 && station_addr == 48'd0, "R1",
            "flags and address in reset", 64'(station_addr), 64'd0);
   endtask

   task automatic test_present_image();
      fill_image(pat_word(0));
      do_load();
      check_protocol();
      check_shadow();
      check(addr_ok == 1'b1, "R8", "valid flag with EEPROM", 64'(addr_ok), 64'd1);
      check(station_addr == exp_mac(), "R8", "station address order",
            64'(station_addr), 64'(exp_mac()));
      check_quiet();
   endtask

   task automatic test_absent_ones();
      fill_image(16'hFFFF);
      do_load();
      check(addr_ok == 1'b0, "R7", "all-ones marker flag", 64'(addr_ok), 64'd0);
      check(station_addr == 48'd0, "R7", "all-ones marker address",
            64'(station_addr), 64'd0);
      check_shadow();
   endtask

   task automatic test_absent_zeros();
      fill_image(16'h0000);
      do_load();
      check(addr_ok == 1'b0, "R7", "all-zeros marker flag", 64'(addr_ok), 64'd0);
      check(station_addr == 48'd0, "R7", "all-zeros marker address",
            64'(station_addr), 64'd0);
      check_protocol();
   endtask

   task automatic test_mixed_marker(input logic [15:0] marker);
      fill_image(marker);
      image[10] = 16'h2200; image[11] = 16'h44FF; image[12] = 16'h6601;
      do_load();
      check(addr_ok == 1'b1, "R8", "mixed marker counts as present",
            64'(addr_ok), 64'd1);
      check(station_addr == 48'h0022_FF44_0166, "R8", "station bytes",
            64'(station_addr), 64'h0022_FF44_0166);
   endtask

   // ---------------- run ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      test_reset_state();
      test_present_image();
      test_absent_ones();
      test_absent_zeros();
      test_mixed_marker(16'h00FF);
      test_mixed_marker(16'hFF00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule